// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Engine

This block frees an I2C bus that a slave device has left stuck with SDA held low. Once it has been armed, it toggles SCL through open-drain pull-down controls, one phase per bit-period tick. It samples SDA near the end of each high phase, and it stops when the slave lets go of SDA or when a programmed number of pulses has been issued. If the bus was freed and the option is set, it finishes with a STOP condition. It then reports whether the recovery succeeded.

Software writes a set of shadow settings: the pulse limit, the STOP option, the early-exit option and the start bit. None of these settings reaches the engine until a load strobe is given. The block acknowledges the load with a busy flag that lasts one cycle. The start bit clears itself when a sequence ends, so software can poll it to see that the sequence has finished. Ordinary master transfers are handled elsewhere.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After a synchronous active-low reset, no line is pulled, `load_busy`, `en_readback`, `clear_ok` and `seq_done` are all 0.
- R2: Shadow inputs have no effect until `load_req` is given; `load_busy` is 1 exactly in the cycle after each cycle with `load_req` high, and the settings are copied into the active set at the end of that busy cycle.
- R3: A load with `cfg_go`=1 while idle sets `en_readback` to 1, and SCL is pulled low from the next cycle on.
- R4: Each pulse holds SCL pulled low for one tick period and released for one tick period; SDA is sampled on the tick that ends the released phase.
- R5: With `cfg_term`=1 the engine stops after the first pulse whose sample sees SDA high.
- R6: Pulsing stops once the pulse count reaches `cfg_thresh`; a threshold of 0 behaves as 1.
- R7: `clear_ok` becomes 1 at completion if any sample in the run saw SDA high, else 0, and keeps that value until the next completion.
- R8: On success with `cfg_stop`=1, the engine pulls SDA while SCL is low for one tick, then releases SCL with SDA still pulled for one tick, then releases SDA; on failure or with `cfg_stop`=0 SDA is never pulled.
- R9: At completion `en_readback` returns to 0 and `seq_done` pulses high for exactly one cycle in the same cycle.
- R10: A load given while a sequence runs does not clear `en_readback` or stop the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit-period phase boundary |
| cfg_thresh | input | THR_W | Shadow pulse limit |
| cfg_stop | input | 1 | Shadow: send STOP after a successful clear |
| cfg_term | input | 1 | Shadow: end early once SDA is seen high |
| cfg_go | input | 1 | Shadow start bit |
| load_req | input | 1 | Strobe that copies the shadow settings into the active set |
| sda_in | input | 1 | Synchronized SDA line level |
| load_busy | output | 1 | High while a load is being applied |
| en_readback | output | 1 | Active start bit; cleared by hardware at completion |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| clear_ok | output | 1 | Result of the last completed sequence |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The case that is hardest to reach from the ports is a load that arrives in the middle of a sequence, because the start bit must survive the load while the other settings are replaced. The bench builds this case with a slave model that keeps SDA low for longer than the limit. It waits until two pulses have been counted, and then loads a word whose start bit is clear. Each other run uses the same slave model, set to release SDA after a chosen number of SCL falls. Together these runs cover release on the limit pulse, a bus that was never stuck, a bus that never releases, and a limit of zero.

// File: rtl/i2cbc_pkg.sv
// Shared definitions for the bus-clear engine.
// Assumes: the sequencer state is encoded in three bits.
package i2cbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOW       = 3'd1,
        ST_HIGH      = 3'd2,
        ST_STP_SETUP = 3'd3,
        ST_STP_HOLD  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/i2cbc_cfg.sv
// Shadow-to-active configuration holder.
// load_req raises load_busy for one cycle, and the shadow values are copied
// at the end of that cycle. The active start bit is cleared by seq_finish;
// while a sequence runs, a load leaves the start bit at 1.
// Assumes: the shadow inputs are stable during the busy cycle.
module i2cbc_cfg #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] sh_thresh,
    input  logic             sh_stop,
    input  logic             sh_term,
    input  logic             sh_go,
    input  logic             load_req,
    input  logic             seq_running,
    input  logic             seq_finish,
    output logic [THR_W-1:0] act_thresh,
    output logic             act_stop,
    output logic             act_term,
    output logic             act_go,
    output logic             load_busy
);

    // Load handshake: busy mirrors the strobe delayed by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) load_busy <= 1'b0;
        else        load_busy <= load_req;
    end

    // Active option fields: copied during the busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_thresh <= '0;
            act_stop   <= 1'b0;
            act_term   <= 1'b0;
        end else if (load_busy) begin
            act_thresh <= sh_thresh;
            act_stop   <= sh_stop;
            act_term   <= sh_term;
        end
    end

    // Active start bit: completion clears it; a load while idle sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        act_go <= 1'b0;
        else if (seq_finish)               act_go <= 1'b0;
        else if (load_busy && !seq_running) act_go <= sh_go;
    end

endmodule

// File: rtl/i2cbc_seq.sv
// Pulse sequencer. It issues SCL pulses (low phase, then high phase, one
// tick each) and samples SDA on the tick that ends each high phase. It
// stops on early release (when term is set) or when the limit is reached,
// and can then append a STOP. fin_ok carries the result on the finish cycle.
// Assumes: tick is a one-cycle strobe; sda_in is already synchronized.
module i2cbc_seq
    import i2cbc_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic [THR_W-1:0] thresh,
    input  logic             term,
    input  logic             stop_en,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             running,
    output logic             finish,
    output logic             fin_ok
);

    seq_state_e       state, state_nx;
    logic [THR_W-1:0] cnt;
    logic             seen_hi;
    logic             ok_hold;
    logic             succ_now;
    logic             limit_hit;
    logic             end_pulses;

    assign succ_now   = seen_hi | sda_in;
    assign limit_hit  = (cnt >= thresh);
    assign end_pulses = (term && sda_in) || limit_hit;

    // Next-state and finish decode.
    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        fin_ok   = 1'b0;
        unique case (state)
            ST_IDLE: if (go) state_nx = ST_LOW;
            ST_LOW:  if (tick) state_nx = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (!end_pulses) begin
                        state_nx = ST_LOW;
                    end else if (succ_now && stop_en) begin
                        state_nx = ST_STP_SETUP;
                    end else begin
                        state_nx = ST_IDLE;
                        finish   = 1'b1;
                        fin_ok   = succ_now;
                    end
                end
            end
            ST_STP_SETUP: if (tick) state_nx = ST_STP_HOLD;
            ST_STP_HOLD: begin
                if (tick) begin
                    state_nx = ST_IDLE;
                    finish   = 1'b1;
                    fin_ok   = ok_hold;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pulse counter: cleared at start, bumped on entry to each high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (state == ST_IDLE)              cnt <= '0;
        else if (state == ST_LOW && tick)       cnt <= cnt + 1'b1;
    end

    // SDA-seen-high flag: set by any high-phase sample during the run.
    always_ff @(posedge clk) begin
        if (!rst_n)                              seen_hi <= 1'b0;
        else if (state == ST_IDLE)               seen_hi <= 1'b0;
        else if (state == ST_HIGH && tick)       seen_hi <= succ_now;
    end

    // Result held across the STOP phases.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ok_hold <= 1'b0;
        else if (state == ST_HIGH && tick && end_pulses)   ok_hold <= succ_now;
    end

    // Line controls decoded from the registered state.
    always_comb begin
        scl_pull = (state == ST_LOW) || (state == ST_STP_SETUP);
        sda_pull = (state == ST_STP_SETUP) || (state == ST_STP_HOLD);
        running  = (state != ST_IDLE);
    end

endmodule

// File: rtl/i2cbc_status.sv
// Result holder. On each finish it latches the result and raises a
// completion pulse for one cycle.
// Assumes: finish is high for at most one cycle per sequence.
module i2cbc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  logic fin_ok,
    output logic clear_ok,
    output logic done
);

    // Latch the outcome; hold it until the next completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      clear_ok <= 1'b0;
        else if (finish) clear_ok <= fin_ok;
    end

    // Completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

endmodule

// File: rtl/i2c_bus_unstick.sv
// Top of the bus-clear recovery engine: it connects the configuration
// holder, the pulse sequencer and the result holder.
// Assumes: bit_tick is a one-cycle strobe at the bit-phase rate; sda_in is
// synchronized; scl_pull/sda_pull drive open-drain pads outside the block.
module i2c_bus_unstick #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic             cfg_stop,
    input  logic             cfg_term,
    input  logic             cfg_go,
    input  logic             load_req,
    input  logic             sda_in,
    output logic             load_busy,
    output logic             en_readback,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             clear_ok,
    output logic             seq_done
);

    logic [THR_W-1:0] a_thresh;
    logic             a_stop, a_term, a_go;
    logic             running, finish, fin_ok;

    i2cbc_cfg #(.THR_W(THR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sh_thresh  (cfg_thresh),
        .sh_stop    (cfg_stop),
        .sh_term    (cfg_term),
        .sh_go      (cfg_go),
        .load_req   (load_req),
        .seq_running(running),
        .seq_finish (finish),
        .act_thresh (a_thresh),
        .act_stop   (a_stop),
        .act_term   (a_term),
        .act_go     (a_go),
        .load_busy  (load_busy)
    );

    i2cbc_seq #(.THR_W(THR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .go      (a_go),
        .thresh  (a_thresh),
        .term    (a_term),
        .stop_en (a_stop),
        .sda_in  (sda_in),
        .scl_pull(scl_pull),
        .sda_pull(sda_pull),
        .running (running),
        .finish  (finish),
        .fin_ok  (fin_ok)
    );

    i2cbc_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .fin_ok  (fin_ok),
        .clear_ok(clear_ok),
        .done    (seq_done)
    );

    assign en_readback = a_go;

endmodule

// File: rtl/i2cbc_checker.sv
// Port-level properties of the bus-clear engine, bound to the top.
module i2cbc_checker (
    input logic clk,
    input logic rst_n,
    input logic load_req,
    input logic load_busy,
    input logic en_readback,
    input logic seq_done,
    input logic scl_pull,
    input logic sda_pull
);

    // R2: every strobe is acknowledged in the next cycle
    p_load_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> load_busy);

    // R2: busy never appears without a strobe
    p_load_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> !load_busy);

    // R9: no line is pulled while the start bit is clear
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_readback |-> (!scl_pull && !sda_pull));

    // R9: the completion pulse comes with a cleared start bit
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !en_readback);

    // R9: the completion pulse lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R8: SDA is pulled only while SCL is held low
    p_stop_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull);

    // R8: SDA is released only while SCL is released (STOP)
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_pull);

endmodule

bind i2c_bus_unstick i2cbc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .load_busy  (load_busy),
    .en_readback(en_readback),
    .seq_done   (seq_done),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull)
);

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;

    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 4;
    localparam int THR_W    = 8;
    localparam int NV       = 8;
    // thr, stop, term, release_after, exp_pulses, exp_ok, exp_stop
    localparam int VEC [NV][7] = '{
        '{18, 1, 1,   3, 3, 1, 1},
        '{18, 0, 1,   3, 3, 1, 0},
        '{ 5, 1, 0,   2, 5, 1, 1},
        '{ 5, 1, 1,   9, 5, 0, 0},
        '{ 4, 1, 1,   0, 1, 1, 1},
        '{ 0, 0, 0, 200, 1, 0, 0},
        '{ 7, 0, 1,   7, 7, 1, 0},
        '{ 1, 1, 0,   1, 1, 1, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_tick = 1'b0;
    logic [THR_W-1:0] cfg_thresh = '0;
    logic             cfg_stop = 1'b0, cfg_term = 1'b0, cfg_go = 1'b0;
    logic             load_req = 1'b0;
    logic             sda_in;
    logic             load_busy, en_readback, scl_pull, sda_pull, clear_ok, seq_done;

    int n_run = 0, n_fail = 0;
    int rel_k = 0;
    int lowcnt = 0, plen = 0, last_low = 0, last_high = 0, done_cnt = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0, saw_stop = 1'b0, stop_bad = 1'b0;
    logic mon_clr = 1'b0;

    i2c_bus_unstick #(.THR_W(THR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_thresh(cfg_thresh), .cfg_stop(cfg_stop), .cfg_term(cfg_term),
        .cfg_go(cfg_go), .load_req(load_req), .sda_in(sda_in),
        .load_busy(load_busy), .en_readback(en_readback), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .clear_ok(clear_ok), .seq_done(seq_done)
    );

    always #(CLK_P/2) clk = ~clk;

    // Slave model: SDA held low until rel_k SCL pulses have been seen.
    assign sda_in = !sda_pull && ((rel_k == 0) || (lowcnt >= rel_k));

    // Bit-period tick generator, driven away from the active edge.
    initial begin
        forever begin
            for (int i = 0; i < TICK_DIV; i++) begin
                @(negedge clk);
                bit_tick = (i == TICK_DIV - 1);
            end
        end
    end

    // Line monitor: pulse count, phase lengths, STOP shape, done width.
    always @(posedge clk) begin
        if (mon_clr) begin
            lowcnt <= 0; plen <= 0; last_low <= 0; last_high <= 0;
            saw_stop <= 1'b0; stop_bad <= 1'b0; done_cnt <= 0;
        end else begin
            if (scl_pull && !prev_scl && !sda_pull) lowcnt <= lowcnt + 1;
            if (scl_pull != prev_scl) begin
                if (scl_pull) last_high <= plen;
                else          last_low  <= plen;
                plen <= 1;
            end else begin
                plen <= plen + 1;
            end
            if (sda_pull && !scl_pull) saw_stop <= 1'b1;
            if (sda_pull && !prev_sda && !scl_pull) stop_bad <= 1'b1;
            if (seq_done) done_cnt <= done_cnt + 1;
        end
        prev_scl <= scl_pull;
        prev_sda <= sda_pull;
    end

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int thr, input int st, input int tm, input int go);
        cfg_thresh = thr[THR_W-1:0];
        cfg_stop   = st[0];
        cfg_term   = tm[0];
        cfg_go     = go[0];
        load_req   = 1'b1;
        @(negedge clk);
        load_req   = 1'b0;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wait_done(output logic got);
        got = 1'b0;
        for (int i = 0; i < 5000 && !got; i++) begin
            @(negedge clk);
            if (seq_done) got = 1'b1;
        end
    endtask

    logic got;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!scl_pull && !sda_pull, "R1", {scl_pull, sda_pull}, 0);
        chk(!load_busy && !en_readback, "R1", {load_busy, en_readback}, 0);
        chk(!clear_ok && !seq_done, "R1", {clear_ok, seq_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: shadow start bit without a load is ignored
        clear_mon();
        rel_k = 0;
        cfg_thresh = 8'd3; cfg_stop = 1'b0; cfg_term = 1'b0; cfg_go = 1'b1;
        repeat (30) @(negedge clk);
        chk(lowcnt == 0 && !scl_pull, "R2", lowcnt, 0);
        chk(!en_readback, "R2", en_readback, 0);
        // R2: busy for exactly the cycle after the strobe
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        chk(load_busy, "R2", load_busy, 1);
        @(negedge clk);
        chk(!load_busy, "R2", load_busy, 0);
        // R3: start bit visible, SCL pulled in the next cycle
        chk(en_readback, "R3", en_readback, 1);
        @(negedge clk);
        chk(scl_pull, "R3", scl_pull, 1);
        wait_done(got);
        chk(got, "R9", got, 1);
        chk(lowcnt == 3, "R6", lowcnt, 3);
        chk(clear_ok, "R7", clear_ok, 1);

        // Table of runs
        for (int v = 0; v < NV; v++) begin
            clear_mon();
            rel_k = VEC[v][3];
            load_cfg(VEC[v][0], VEC[v][1], VEC[v][2], 1);
            wait_done(got);
            chk(got, "R9", got, 1);
            chk(!en_readback, "R9", en_readback, 0);
            if (VEC[v][2] != 0) chk(lowcnt == VEC[v][4], "R5", lowcnt, VEC[v][4]);
            else                chk(lowcnt == VEC[v][4], "R6", lowcnt, VEC[v][4]);
            chk(clear_ok == VEC[v][5][0], "R7", clear_ok, VEC[v][5]);
            chk(saw_stop == VEC[v][6][0], "R8", saw_stop, VEC[v][6]);
            chk(!stop_bad, "R8", stop_bad, 0);
            if (VEC[v][4] >= 2 || VEC[v][6] != 0) begin
                chk(last_low == TICK_DIV, "R4", last_low, TICK_DIV);
                chk(last_high == TICK_DIV, "R4", last_high, TICK_DIV);
            end
            @(negedge clk);
            chk(!seq_done && done_cnt == 1, "R9", done_cnt, 1);
            // R7: result holds while idle
            repeat (10) @(negedge clk);
            chk(clear_ok == VEC[v][5][0], "R7", clear_ok, VEC[v][5]);
        end

        // R10: load with start bit 0 in mid-run leaves the run going
        clear_mon();
        rel_k = 200;
        load_cfg(6, 0, 0, 1);
        for (int i = 0; i < 2000 && lowcnt < 2; i++) @(negedge clk);
        load_cfg(6, 0, 0, 0);
        @(negedge clk);
        chk(en_readback, "R10", en_readback, 1);
        wait_done(got);
        chk(got && lowcnt == 6, "R10", lowcnt, 6);
        chk(!clear_ok, "R10", clear_ok, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 190000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule